// File: doc/BRIEF.md
# Half-Duplex Transmit Timing Controller

This block paces frame transmission for an 802.3 MAC on a shared medium. It works in bit-time units: a one-cycle `tick` input marks each bit time, and every gap, jam and backoff length is counted in ticks. A requester raises `tx_req` and holds it while a frame is pending. The controller answers with a one-cycle `tx_start` once the inter-packet gap has elapsed. The serialiser then signals `frame_done` at the end of the frame.

While a frame is on the wire, a collision makes the controller jam the line for a fixed number of bit times. It then either schedules a retry after a truncated binary exponential backoff, or drops the frame. A frame is dropped when the collision limit is reached or when the collision came late. The random slot count comes from a free-running LFSR. In full-duplex mode the collision input is ignored and only the gap is enforced.

Parameters (defaults): `IPG_BITS` = 96, `SLOT_BITS` = 512, `JAM_BITS` = 32, `ATTEMPT_LIMIT` = 16, `BACKOFF_LIMIT` = 10.

Top module: `hdtx_ctrl`

## Requirements
- R1: While `rst_n` is low, `tx_start`, `jam`, `retry` and `drop` are low, and the gap counter and collision count are zero. The first start after reset therefore needs `IPG_BITS` ticks.
- R2: In the idle state, with `tx_req` high and the gap counter equal to `IPG_BITS`, a one-cycle `tx_start` follows in the next cycle and a transmit attempt begins. The requester keeps `tx_req` high until the frame ends with `frame_done` or `drop`.
- R3: The gap counter is cleared in every cycle in which an own transmit attempt or a jam is in progress. Otherwise it counts ticks, saturating at `IPG_BITS`. After a successful frame the gap is therefore measured from the frame's end.
- R4: In half-duplex mode, while the frame's collision count is nonzero and `crs` is high, the gap counter is held at zero. After a collision the gap is therefore measured from the fall of carrier sense.
- R5: In half-duplex mode, `col` high during a transmit attempt is a collision; it takes priority over `frame_done` in the same cycle. `jam` goes high in the next cycle and stays high for exactly `JAM_BITS` ticks.
- R6: When a jam ends and the frame is not dropped, `retry` pulses for one cycle. The controller then waits r × `SLOT_BITS` ticks before returning to idle. After the n-th collision, r is the low min(n, `BACKOFF_LIMIT`) bits of the LFSR value.
- R7: The LFSR is 16 bits wide, resets to 0xACE1 and shifts left every clock cycle. The new bit 0 is the XOR of bits 15, 13, 12 and 10. r is taken from the value held in the cycle in which the jam ends.
- R8: The `ATTEMPT_LIMIT`-th collision of a frame ends with a one-cycle `drop` at the end of its jam instead of `retry`.
- R9: A collision that occurs when `SLOT_BITS` or more ticks have passed since the attempt began is late. It ends with `drop` at the end of its jam, whatever the collision count.
- R10: The collision count returns to zero after `frame_done` ends an attempt and after a drop. The next frame's first backoff therefore draws from a single bit.
- R11: With `full_duplex` high, `col` is ignored: no jam, retry or drop occurs, and the gap is still enforced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per bit time |
| full_duplex | input | 1 | High selects full-duplex mode (collisions ignored) |
| tx_req | input | 1 | Frame pending; held until frame_done or drop |
| crs | input | 1 | Carrier sense from the medium |
| col | input | 1 | Collision detect from the medium |
| frame_done | input | 1 | Current attempt finished transmitting |
| tx_start | output | 1 | One-cycle pulse: begin transmitting the frame |
| jam | output | 1 | High while the jam pattern must be sent |
| retry | output | 1 | One-cycle pulse: frame will be re-attempted after backoff |
| drop | output | 1 | One-cycle pulse: frame abandoned |

## Verification
The bench compares every cycle against a behavioural model while the tick arrives every cycle or every second cycle. A clean frame followed by a back-to-back request separates gap timing from the end of the own frame from timing after a collision. There, carrier sense is held well past the jam and the backoff, so a gap counted from the wrong reference shows up as a mis-timed start. A run of collisions on one frame walks the backoff window through its truncation point and up to the attempt limit. A collision placed beyond one slot separates the late-drop path, a collision coinciding with frame end checks priority, and a full-duplex frame with collision pulses checks that they are ignored.

// File: rtl/hdtx_pkg.sv
package hdtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TX      = 2'd1,
    ST_JAM     = 2'd2,
    ST_BACKOFF = 2'd3
  } hdtx_state_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  // One step of the 16-bit pseudo-random source (taps 15,13,12,10).
  function automatic logic [15:0] lfsr_step(input logic [15:0] cur);
    logic fb;
    fb = cur[15] ^ cur[13] ^ cur[12] ^ cur[10];
    return {cur[14:0], fb};
  endfunction

endpackage

// File: rtl/hdtx_gap_timer.sv
module hdtx_gap_timer #(
  parameter int IPG_BITS = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic gap_ok
);
  localparam int GAP_W = $clog2(IPG_BITS + 1);

  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (clear) begin
      gap_cnt <= '0;
    end else if (tick && (gap_cnt != GAP_W'(IPG_BITS))) begin
      gap_cnt <= gap_cnt + GAP_W'(1);
    end
  end

  assign gap_ok = (gap_cnt == GAP_W'(IPG_BITS));
endmodule

// File: rtl/hdtx_lfsr.sv
module hdtx_lfsr #(
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  import hdtx_pkg::*;

  logic [15:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LFSR_SEED;
    else        state_q <= lfsr_step(state_q);
  end

  assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/hdtx_backoff_calc.sv
module hdtx_backoff_calc #(
  parameter int SLOT_BITS     = 512,
  parameter int BACKOFF_LIMIT = 10,
  parameter int NCOL_W        = 5,
  parameter int BO_W          = 20
) (
  input  logic [NCOL_W-1:0]        ncol,
  input  logic [BACKOFF_LIMIT-1:0] rnd,
  output logic [BO_W-1:0]          delay
);
  logic [BACKOFF_LIMIT-1:0] slots;

  // Bit i of the slot count survives only once more than i collisions occurred,
  // which truncates the window at BACKOFF_LIMIT bits.
  for (genvar i = 0; i < BACKOFF_LIMIT; i++) begin : g_win
    assign slots[i] = rnd[i] & (32'(ncol) > i);
  end

  assign delay = BO_W'(slots) * BO_W'(SLOT_BITS);
endmodule

// File: rtl/hdtx_ctrl.sv
module hdtx_ctrl #(
  parameter int IPG_BITS      = 96,
  parameter int SLOT_BITS     = 512,
  parameter int JAM_BITS      = 32,
  parameter int ATTEMPT_LIMIT = 16,
  parameter int BACKOFF_LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic full_duplex,
  input  logic tx_req,
  input  logic crs,
  input  logic col,
  input  logic frame_done,
  output logic tx_start,
  output logic jam,
  output logic retry,
  output logic drop
);
  import hdtx_pkg::*;

  localparam int BIT_W  = $clog2(SLOT_BITS + 1);
  localparam int JAM_W  = $clog2(JAM_BITS + 1);
  localparam int NCOL_W = $clog2(ATTEMPT_LIMIT + 1);
  localparam int BO_W   = BACKOFF_LIMIT + $clog2(SLOT_BITS + 1);

  hdtx_state_e          state;
  logic [BIT_W-1:0]     bit_cnt;
  logic [JAM_W-1:0]     jam_cnt;
  logic [NCOL_W-1:0]    ncol;
  logic                 late_q;
  logic [BO_W-1:0]      bo_cnt;
  logic [BO_W-1:0]      bo_delay;
  logic [BACKOFF_LIMIT-1:0] rnd;

  // Named internal events, also observed by the checker.
  logic gap_ok;
  logic gap_clear;
  logic start_evt;
  logic col_evt;
  logic done_evt;
  logic jam_end;
  logic give_up;
  logic bo_done;

  assign start_evt = (state == ST_IDLE) && tx_req && gap_ok;
  assign col_evt   = (state == ST_TX) && col && !full_duplex;
  assign done_evt  = (state == ST_TX) && frame_done && !col_evt;
  assign jam_end   = (state == ST_JAM) && tick && (jam_cnt == JAM_W'(JAM_BITS - 1));
  assign give_up   = late_q || (ncol == NCOL_W'(ATTEMPT_LIMIT));
  assign bo_done   = (state == ST_BACKOFF) && (bo_cnt == '0);
  assign gap_clear = (state == ST_TX) || (state == ST_JAM) ||
                     ((ncol != '0) && crs && !full_duplex);

  hdtx_gap_timer #(.IPG_BITS(IPG_BITS)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .clear  (gap_clear),
    .gap_ok (gap_ok)
  );

  hdtx_lfsr #(.OUT_W(BACKOFF_LIMIT)) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .rnd   (rnd)
  );

  hdtx_backoff_calc #(
    .SLOT_BITS     (SLOT_BITS),
    .BACKOFF_LIMIT (BACKOFF_LIMIT),
    .NCOL_W        (NCOL_W),
    .BO_W          (BO_W)
  ) u_bo (
    .ncol  (ncol),
    .rnd   (rnd),
    .delay (bo_delay)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      jam_cnt  <= '0;
      ncol     <= '0;
      late_q   <= 1'b0;
      bo_cnt   <= '0;
      tx_start <= 1'b0;
      retry    <= 1'b0;
      drop     <= 1'b0;
    end else begin
      tx_start <= start_evt;
      retry    <= jam_end && !give_up;
      drop     <= jam_end && give_up;
      unique case (state)
        ST_IDLE: begin
          if (start_evt) begin
            state   <= ST_TX;
            bit_cnt <= '0;
          end
        end
        ST_TX: begin
          if (col_evt) begin
            state   <= ST_JAM;
            jam_cnt <= '0;
            late_q  <= (bit_cnt == BIT_W'(SLOT_BITS));
            ncol    <= ncol + NCOL_W'(1);
          end else if (done_evt) begin
            state <= ST_IDLE;
            ncol  <= '0;
          end else if (tick && (bit_cnt != BIT_W'(SLOT_BITS))) begin
            bit_cnt <= bit_cnt + BIT_W'(1);
          end
        end
        ST_JAM: begin
          if (jam_end) begin
            if (give_up) begin
              state <= ST_IDLE;
              ncol  <= '0;
            end else begin
              state  <= ST_BACKOFF;
              bo_cnt <= bo_delay;
            end
          end else if (tick) begin
            jam_cnt <= jam_cnt + JAM_W'(1);
          end
        end
        ST_BACKOFF: begin
          if (bo_done)   state  <= ST_IDLE;
          else if (tick) bo_cnt <= bo_cnt - BO_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign jam = (state == ST_JAM);
endmodule

// File: rtl/hdtx_ctrl_chk.sv
module hdtx_ctrl_chk #(
  parameter int JAM_BITS      = 32,
  parameter int ATTEMPT_LIMIT = 16,
  parameter int NCOL_W        = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              full_duplex,
  input logic              tx_req,
  input logic              col,
  input logic              tx_start,
  input logic              jam,
  input logic              retry,
  input logic              drop,
  input logic              gap_ok,
  input logic [NCOL_W-1:0] ncol
);
  localparam int JT_W = $clog2(JAM_BITS + 2);

  logic [JT_W-1:0] jam_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n)            jam_ticks <= '0;
    else if (!jam)         jam_ticks <= '0;
    else if (tick)         jam_ticks <= jam_ticks + JT_W'(1);
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !tx_start && !retry && !drop);

  assert_start_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(gap_ok) && $past(tx_req));

  assert_jam_from_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam) |-> $past(col) && !$past(full_duplex));

  assert_jam_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam) |-> (jam_ticks == JT_W'(JAM_BITS)));

  assert_single_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_start, retry, drop}));

  assert_drop_ends_jam_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop || retry) |-> $past(jam) && !jam);

  assert_count_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ncol) <= ATTEMPT_LIMIT);

  assert_fd_no_jam_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && $past(full_duplex)) |-> !$rose(jam));
endmodule

bind hdtx_ctrl hdtx_ctrl_chk #(
  .JAM_BITS      (JAM_BITS),
  .ATTEMPT_LIMIT (ATTEMPT_LIMIT),
  .NCOL_W        (NCOL_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .full_duplex (full_duplex),
  .tx_req      (tx_req),
  .col         (col),
  .tx_start    (tx_start),
  .jam         (jam),
  .retry       (retry),
  .drop        (drop),
  .gap_ok      (gap_ok),
  .ncol        (ncol)
);

// File: tb/hdtx_ctrl_tb_top.sv
`timescale 1ns/1ps
module hdtx_ctrl_tb_top;
  localparam int IPG  = 12;
  localparam int SLOT = 16;
  localparam int JAMT = 4;
  localparam int ATT  = 16;
  localparam int LIM  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic full_duplex = 1'b0;
  logic tx_req = 1'b0;
  logic crs = 1'b0;
  logic col = 1'b0;
  logic frame_done = 1'b0;
  logic tx_start, jam, retry, drop;

  always #2.5 clk = ~clk;

  hdtx_ctrl #(
    .IPG_BITS(IPG), .SLOT_BITS(SLOT), .JAM_BITS(JAMT),
    .ATTEMPT_LIMIT(ATT), .BACKOFF_LIMIT(LIM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .full_duplex(full_duplex),
    .tx_req(tx_req), .crs(crs), .col(col), .frame_done(frame_done),
    .tx_start(tx_start), .jam(jam), .retry(retry), .drop(drop)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int tick_div = 1;
  bit finished = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // state: 0 idle, 1 sending, 2 jamming, 3 waiting out backoff
  int m_state, m_gap, m_bit, m_jam, m_ncol, m_late, m_bo, m_lfsr;
  int m_start, m_retry, m_drop;

  function automatic int next_rand(input int v);
    int b;
    b = ((v >> 15) ^ (v >> 13) ^ (v >> 12) ^ (v >> 10)) & 1;
    return ((v * 2) + b) % 65536;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_gap = 0; m_bit = 0; m_jam = 0; m_ncol = 0;
      m_late = 0; m_bo = 0; m_lfsr = 'hACE1;
      m_start = 0; m_retry = 0; m_drop = 0;
    end else begin
      automatic bit hit   = (m_state == 1) && col && !full_duplex;
      automatic bit jdone = (m_state == 2) && tick && (m_jam == JAMT - 1);
      automatic bit quit  = m_late != 0 || m_ncol == ATT;
      automatic bit go    = (m_state == 0) && tx_req && (m_gap == IPG);
      automatic bit wipe  = (m_state == 1) || (m_state == 2) ||
                            (m_ncol != 0 && crs && !full_duplex);
      automatic int width = (m_ncol < LIM) ? m_ncol : LIM;
      automatic int slots = m_lfsr % (1 << width);
      if (wipe) m_gap = 0;
      else if (tick && m_gap < IPG) m_gap++;
      m_start = go;
      m_retry = jdone && !quit;
      m_drop  = jdone && quit;
      case (m_state)
        0: if (go) begin m_state = 1; m_bit = 0; end
        1: if (hit) begin
             m_state = 2; m_jam = 0; m_late = (m_bit >= SLOT); m_ncol++;
           end else if (frame_done) begin
             m_state = 0; m_ncol = 0;
           end else if (tick && m_bit < SLOT) m_bit++;
        2: if (jdone) begin
             if (quit) begin m_state = 0; m_ncol = 0; end
             else begin m_state = 3; m_bo = slots * SLOT; end
           end else if (tick) m_jam++;
        default: if (m_bo == 0) m_state = 0; else if (tick) m_bo--;
      endcase
      m_lfsr = next_rand(m_lfsr);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2/R3/R4/R7 tx_start", int'(tx_start), m_start);
      check("R5/R11 jam", int'(jam), int'(m_state == 2));
      check("R6/R7 retry", int'(retry), m_retry);
      check("R8/R9/R10 drop", int'(drop), m_drop);
    end
  end

  // stimulus helpers
  int n_start = 0, n_retry = 0, n_drop = 0, n_jamrise = 0;
  bit jam_prev = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      tick = (cyc % tick_div) == 0;
      if (tx_start) n_start++;
      if (retry) n_retry++;
      if (drop) n_drop++;
      if (jam && !jam_prev) n_jamrise++;
      jam_prev = jam;
    end
  end

  task automatic wait_start();
    do @(negedge clk); while (!tx_start);
  endtask

  task automatic wait_outcome();
    do @(negedge clk); while (!(retry || drop));
  endtask

  task automatic pulse_col(input int crs_len);
    col = 1'b1; crs = 1'b1;
    @(negedge clk);
    col = 1'b0;
    repeat (crs_len) @(negedge clk);
    crs = 1'b0;
  endtask

  task automatic end_frame();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    tx_req = 1'b0;
  endtask

  task automatic run_all();
    int c0, r0, d0, j0, t_fall, t_go;
    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1 tx_start in reset", int'(tx_start), 0);
    check("R1 jam in reset", int'(jam), 0);
    check("R1 retry/drop in reset", int'(retry | drop), 0);
    @(negedge clk); rst_n = 1'b1;
    c0 = cyc;
    tx_req = 1'b1;
    // R1/R2: first start needs IPG ticks
    wait_start();
    check("R1 first start delayed by gap", int'(cyc - c0 >= IPG), 1);
    repeat (6) @(negedge clk);
    // R3: back-to-back frame, gap from frame end
    frame_done = 1'b1; @(negedge clk); frame_done = 1'b0;
    c0 = cyc;
    wait_start();
    check("R3 gap from own frame end", int'(cyc - c0 >= IPG), 1);
    repeat (5) @(negedge clk);
    end_frame();

    // R4/R6: early collision, slow tick, long carrier
    tick_div = 2;
    r0 = n_retry;
    tx_req = 1'b1;
    wait_start();
    repeat (2) @(negedge clk);
    pulse_col(70);
    t_fall = cyc;
    wait_start();
    t_go = cyc;
    check("R6 one retry after first collision", n_retry - r0, 1);
    check("R4 restart waits for carrier fall plus gap", int'(t_go - t_fall >= IPG), 1);
    repeat (3) @(negedge clk);
    end_frame();

    // R9: late collision dropped
    tick_div = 1;
    r0 = n_retry; d0 = n_drop;
    repeat (3) @(negedge clk);
    tx_req = 1'b1;
    wait_start();
    repeat (SLOT + 4) @(negedge clk);
    pulse_col(2);
    wait_outcome();
    check("R9 late collision drops", n_drop - d0, 1);
    check("R9 late collision no retry", n_retry - r0, 0);
    tx_req = 1'b0;

    // R8: attempt limit, backoff window truncated at LIM bits (R6)
    r0 = n_retry; d0 = n_drop;
    repeat (3) @(negedge clk);
    tx_req = 1'b1;
    for (int k = 0; k < ATT; k++) begin
      wait_start();
      @(negedge clk);
      pulse_col(3);
      wait_outcome();
    end
    tx_req = 1'b0;
    check("R8 retries before limit", n_retry - r0, ATT - 1);
    check("R8 drop at limit", n_drop - d0, 1);

    // R10: count cleared after drop, single-bit backoff next
    r0 = n_retry;
    repeat (3) @(negedge clk);
    tx_req = 1'b1;
    wait_start();
    pulse_col(2);
    wait_outcome();
    check("R10 fresh frame retries after one collision", n_retry - r0, 1);
    wait_start();
    repeat (2) @(negedge clk);
    end_frame();

    // R11: full duplex ignores collisions
    full_duplex = 1'b1;
    j0 = n_jamrise; r0 = n_retry; d0 = n_drop;
    repeat (2) @(negedge clk);
    tx_req = 1'b1;
    wait_start();
    pulse_col(1);
    @(negedge clk);
    pulse_col(1);
    end_frame();
    repeat (JAMT + 4) @(negedge clk);
    check("R11 no jam in full duplex", n_jamrise - j0, 0);
    check("R11 no retry/drop in full duplex", (n_retry - r0) + (n_drop - d0), 0);
    full_duplex = 1'b0;

    // R5: collision and frame end in the same cycle
    j0 = n_jamrise; r0 = n_retry;
    repeat (2) @(negedge clk);
    tx_req = 1'b1;
    wait_start();
    col = 1'b1; frame_done = 1'b1; crs = 1'b1;
    @(negedge clk);
    col = 1'b0; frame_done = 1'b0; crs = 1'b0;
    wait_outcome();
    check("R5 collision wins over frame end", n_jamrise - j0, 1);
    check("R5 retry after tied collision", n_retry - r0, 1);
    wait_start();
    repeat (2) @(negedge clk);
    end_frame();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=complete");
      end
    join_any
    disable fork;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule